// File: doc/BRIEF.md
# Removable Card Bus Access Decoder

This block sits on the card side of a removable storage card's parallel host bus. It watches the address lines, the two active-low card enables, the attribute/common select line and the four strobes (memory read, memory write, I/O read, I/O write). From these it works out which internal byte register the host is addressing and which byte lanes take part. It then moves data between the 16-bit host bus and a small internal byte register file. A 16-bit holding register backs the data register. The block also drives the active-low indication that the addressed port is 16 bits wide.

The card runs in one of three modes. If the memory-read strobe is low while reset is held, the block latches direct disk-interface mode for good. Otherwise it starts in memory mode, where reads and writes go to attribute memory or to memory-mapped task-file registers. It moves to I/O mode when the host sets bit 0 of the first attribute byte. All host inputs are treated as asynchronous. They pass through a synchronizer into the internal clock, so every response appears a fixed number of clocks after the bus settles. The host data bus is modelled as separate input and output buses plus an output-enable pin.

Top module: `card_bus_decoder`

## Requirements
- R1: While `rst` is high, `oe_n` is sampled. If it is low when reset ends, `mode_o` becomes 2 (disk) and stays 2 until the next reset. Otherwise `mode_o` becomes 0 (memory). The value 3 never appears.
- R2: In memory mode, `iord_n` and `iowr_n` have no effect: reads through them leave `host_doe` low, and writes through them leave the register file unchanged.
- R3: A write to attribute byte 0 (even address 0, `reg_n` low) moves the mode to 1 (I/O) when data bit 0 is 1, and back to 0 when it is 0. The mode cannot leave disk mode this way.
- R4: In memory or I/O mode, a task-file access with both enables low is a word access to register pair A[2:1]. The even byte (A0=0) is on D7:D0 and the odd byte (A0=1) is on D15:D8. Pair 0 is the 16-bit data register.
- R5: In memory or I/O mode, an access with only `ce_lo_n` low moves the byte at A[2:0] on D7:D0, whether that byte is even or odd. A read returns 0xFF on D15:D8. Byte 0 is the low half of the data register.
- R6: In memory or I/O mode, an access with only `ce_hi_n` low always reaches the odd byte of pair A[2:1] on D15:D8. A read returns 0xFF on D7:D0.
- R7: Attribute memory (memory strobes with `reg_n` low) holds one byte at each even address, indexed by A[ATTR_AW:1], on D7:D0 only. D15:D8 read 0xFF. In byte mode an odd address reads 0xFF on both lanes and a write to it is dropped.
- R8: In disk mode, only A[2:0] are decoded. With only `ce_lo_n` low, address 0 is the 16-bit data register on D15:D0. Addresses 1 to 7 are byte registers on D7:D0, and reads return 0xFF on D15:D8.
- R9: In disk mode, with only `ce_hi_n` low at address 6, a read returns the status byte (task-file byte 7) on D7:D0. A write goes to the control byte on `ctl_byte_o` and leaves task-file byte 6 unchanged. Reset clears the control byte.
- R10: A write takes the data present on `host_din` at the rising (trailing) edge of its strobe, not the data present when the strobe fell.
- R11: `port16_n` is low while the card is selected at the data-register address: A[2:1]=0 in I/O mode with `reg_n` low, or A[2:0]=0 with only `ce_lo_n` low in disk mode. It is high at all other times, including throughout memory mode.
- R12: `host_doe` is high only while a read strobe accepted for this card is active, and it drops again once the strobe is released. Reset leaves it low.
- R13: In I/O mode, I/O strobes are accepted only when `reg_n` is low. With `reg_n` high, an I/O read does not drive the bus and an I/O write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset; the mode strap is sampled while it is high |
| host_addr | input | ADDR_W | Host address lines |
| ce_lo_n | input | 1 | Low card enable (even byte or A0-selected byte) |
| ce_hi_n | input | 1 | High card enable (odd byte; alternate register pair in disk mode) |
| reg_n | input | 1 | Low selects attribute memory or I/O cycle, high selects common memory |
| oe_n | input | 1 | Memory read strobe; mode strap during reset |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| host_din | input | 2*BYTE_W | Data from the host |
| host_dout | output | 2*BYTE_W | Data to the host |
| host_doe | output | 1 | Enables the card's drivers onto the host data bus |
| port16_n | output | 1 | Low when the addressed port is 16 bits wide |
| mode_o | output | 2 | Current mode: 0 memory, 1 I/O, 2 disk |
| ctl_byte_o | output | BYTE_W | Device control byte written in disk mode |

## Verification
The bench builds the block with its default parameters: an 11-bit address, 8-bit bytes, an eight-byte task file, eight attribute bytes and a two-stage synchronizer. With the eight-byte task file, the alternate-status address, the status mirror and the data register pair are reachable with three address bits. Setting the upper address bits during disk-mode accesses then shows that only the low three bits are decoded. The two-stage synchronizer fixes the read latency at three clocks, which lets the bench change write data while the strobe is low and still check trailing-edge capture.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  typedef enum logic [1:0] {
    MODE_MEM  = 2'd0,
    MODE_IO   = 2'd1,
    MODE_DISK = 2'd2
  } mode_e;

  // Order of the host control lines inside the synchronized vector
  localparam int SY_CE_LO = 0;
  localparam int SY_CE_HI = 1;
  localparam int SY_REG   = 2;
  localparam int SY_OE    = 3;
  localparam int SY_WE    = 4;
  localparam int SY_IORD  = 5;
  localparam int SY_IOWR  = 6;
  localparam int SY_W     = 7;
endpackage

// File: rtl/cbd_sync.sv
module cbd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cbd_mode_ctl.sv
module cbd_mode_ctl
  import cbd_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  strap_n,
  input  logic  cfg_wr,
  input  logic  cfg_val,
  output mode_e mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= strap_n ? MODE_MEM : MODE_DISK;
    end else if (cfg_wr && mode_q != MODE_DISK) begin
      mode_q <= cfg_val ? MODE_IO : MODE_MEM;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cbd_regfile.sv
module cbd_regfile #(
  parameter int BYTE_W  = 8,
  parameter int TF_AW   = 3,
  parameter int ATTR_AW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TF_AW-2:0]    pair,
  input  logic                ev_wr,
  input  logic [BYTE_W-1:0]   ev_wdata,
  input  logic                od_wr,
  input  logic [BYTE_W-1:0]   od_wdata,
  input  logic                hold_lo_wr,
  input  logic                hold_hi_wr,
  input  logic [2*BYTE_W-1:0] hold_wdata,
  input  logic [ATTR_AW-1:0]  attr_idx,
  input  logic                attr_wr,
  input  logic [BYTE_W-1:0]   attr_wdata,
  input  logic                ctl_wr,
  input  logic [BYTE_W-1:0]   ctl_wdata,
  output logic [BYTE_W-1:0]   ev_rd,
  output logic [BYTE_W-1:0]   od_rd,
  output logic [2*BYTE_W-1:0] hold_rd,
  output logic [BYTE_W-1:0]   attr_rd,
  output logic [BYTE_W-1:0]   status_rd,
  output logic [BYTE_W-1:0]   ctl_rd
);
  localparam int PAIRS      = 1 << (TF_AW - 1);
  localparam int ATTR_DEPTH = 1 << ATTR_AW;

  // Even and odd byte banks: one write port each
  logic [BYTE_W-1:0] ev_mem   [PAIRS];
  logic [BYTE_W-1:0] od_mem   [PAIRS];
  logic [BYTE_W-1:0] attr_mem [ATTR_DEPTH];
  logic [2*BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0]   ctl_q;

  always_ff @(posedge clk) if (ev_wr)   ev_mem[pair]       <= ev_wdata;
  always_ff @(posedge clk) if (od_wr)   od_mem[pair]       <= od_wdata;
  always_ff @(posedge clk) if (attr_wr) attr_mem[attr_idx] <= attr_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (hold_lo_wr) hold_q[BYTE_W-1:0]        <= hold_wdata[BYTE_W-1:0];
      if (hold_hi_wr) hold_q[2*BYTE_W-1:BYTE_W] <= hold_wdata[2*BYTE_W-1:BYTE_W];
      if (ctl_wr)     ctl_q                     <= ctl_wdata;
    end
  end

  assign ev_rd     = ev_mem[pair];
  assign od_rd     = od_mem[pair];
  assign status_rd = od_mem[PAIRS-1];
  assign attr_rd   = attr_mem[attr_idx];
  assign hold_rd   = hold_q;
  assign ctl_rd    = ctl_q;
endmodule

// File: rtl/card_bus_decoder.sv
module card_bus_decoder
  import cbd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BYTE_W      = 8,
  parameter int TF_AW       = 3,
  parameter int ATTR_AW     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                ce_lo_n,
  input  logic                ce_hi_n,
  input  logic                reg_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic                iord_n,
  input  logic                iowr_n,
  input  logic [2*BYTE_W-1:0] host_din,
  output logic [2*BYTE_W-1:0] host_dout,
  output logic                host_doe,
  output logic                port16_n,
  output logic [1:0]          mode_o,
  output logic [BYTE_W-1:0]   ctl_byte_o
);
  localparam int DW     = 2 * BYTE_W;
  localparam int PAIR_W = TF_AW - 1;
  localparam logic [TF_AW-1:0]  ALT_IDX = TF_AW'((1 << TF_AW) - 2);
  localparam logic [BYTE_W-1:0] FILL    = '1;

  // ---------------- synchronized host controls ----------------
  logic [SY_W-1:0] raw, syn;
  assign raw = {iowr_n, iord_n, we_n, oe_n, reg_n, ce_hi_n, ce_lo_n};

  cbd_sync #(.W(SY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw),
    .q   (syn)
  );

  logic sel_lo, sel_hi, reg_s, oe_s, we_s, iord_s, iowr_s;
  assign sel_lo = ~syn[SY_CE_LO];
  assign sel_hi = ~syn[SY_CE_HI];
  assign reg_s  = syn[SY_REG];
  assign oe_s   = syn[SY_OE];
  assign we_s   = syn[SY_WE];
  assign iord_s = syn[SY_IORD];
  assign iowr_s = syn[SY_IOWR];

  logic we_prev, iowr_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev   <= 1'b1;
      iowr_prev <= 1'b1;
    end else begin
      we_prev   <= we_s;
      iowr_prev <= iowr_s;
    end
  end

  logic we_rise, iowr_rise;
  assign we_rise   = we_s & ~we_prev;
  assign iowr_rise = iowr_s & ~iowr_prev;

  // ---------------- mode ----------------
  mode_e mode;
  logic  cfg_wr;

  cbd_mode_ctl u_mode (
    .clk     (clk),
    .rst     (rst),
    .strap_n (oe_s),
    .cfg_wr  (cfg_wr),
    .cfg_val (host_din[0]),
    .mode_o  (mode)
  );

  // ---------------- address decode ----------------
  logic [TF_AW-1:0]   idx;
  logic [PAIR_W-1:0]  pair;
  logic [ATTR_AW-1:0] aidx;
  logic a0, tf_win, attr_win, is_disk;
  logic word, lo_only, hi_only, sel_ok;
  logic io_path_ok, mem_path_ok;
  logic rd_io, rd_mem, wr_io, wr_mem, rd_act, wr_any, is_attr;

  assign idx      = host_addr[TF_AW-1:0];
  assign pair     = host_addr[TF_AW-1:1];
  assign aidx     = host_addr[ATTR_AW:1];
  assign a0       = host_addr[0];
  assign tf_win   = ~|host_addr[ADDR_W-1:TF_AW];
  assign attr_win = ~|host_addr[ADDR_W-1:ATTR_AW+1];
  assign is_disk  = (mode == MODE_DISK);

  assign word    = sel_lo & sel_hi;
  assign lo_only = sel_lo & ~sel_hi;
  assign hi_only = sel_hi & ~sel_lo;
  assign sel_ok  = is_disk ? (sel_lo ^ sel_hi) : (sel_lo | sel_hi);

  assign io_path_ok  = is_disk || (mode == MODE_IO && !reg_s);
  assign mem_path_ok = !is_disk && (!reg_s || mode == MODE_MEM);

  assign rd_io  = io_path_ok && !iord_s && sel_ok && (is_disk || tf_win);
  assign rd_mem = mem_path_ok && !oe_s && sel_ok && (reg_s ? tf_win : attr_win) && !rd_io;
  assign wr_io  = io_path_ok && iowr_rise && sel_ok && (is_disk || tf_win);
  assign wr_mem = mem_path_ok && we_rise && sel_ok && (reg_s ? tf_win : attr_win) && !wr_io;

  assign rd_act  = rd_io | rd_mem;
  assign wr_any  = wr_io | wr_mem;
  assign is_attr = ((rd_mem && !rd_io) || (wr_mem && !wr_io)) && !reg_s;

  // ---------------- register file ----------------
  logic              ev_wr, od_wr, hold_lo_wr, hold_hi_wr, attr_wr, ctl_wr;
  logic [BYTE_W-1:0] ev_wdata, od_wdata;
  logic [BYTE_W-1:0] ev_rd, od_rd, attr_rd, status_rd;
  logic [DW-1:0]     hold_rd;

  cbd_regfile #(.BYTE_W(BYTE_W), .TF_AW(TF_AW), .ATTR_AW(ATTR_AW)) u_rf (
    .clk        (clk),
    .rst        (rst),
    .pair       (pair),
    .ev_wr      (ev_wr),
    .ev_wdata   (ev_wdata),
    .od_wr      (od_wr),
    .od_wdata   (od_wdata),
    .hold_lo_wr (hold_lo_wr),
    .hold_hi_wr (hold_hi_wr),
    .hold_wdata (host_din),
    .attr_idx   (aidx),
    .attr_wr    (attr_wr),
    .attr_wdata (host_din[BYTE_W-1:0]),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (host_din[BYTE_W-1:0]),
    .ev_rd      (ev_rd),
    .od_rd      (od_rd),
    .hold_rd    (hold_rd),
    .attr_rd    (attr_rd),
    .status_rd  (status_rd),
    .ctl_rd     (ctl_byte_o)
  );

  assign cfg_wr = attr_wr && (aidx == '0);

  // ---------------- write steering ----------------
  always_comb begin
    ev_wr      = 1'b0;
    od_wr      = 1'b0;
    hold_lo_wr = 1'b0;
    hold_hi_wr = 1'b0;
    attr_wr    = 1'b0;
    ctl_wr     = 1'b0;
    ev_wdata   = host_din[BYTE_W-1:0];
    od_wdata   = host_din[DW-1:BYTE_W];
    if (wr_any) begin
      if (is_attr) begin
        attr_wr = word || (lo_only && !a0);
      end else if (is_disk) begin
        if (lo_only) begin
          if (idx == '0) begin
            hold_lo_wr = 1'b1;
            hold_hi_wr = 1'b1;
          end else if (a0) begin
            od_wr    = 1'b1;
            od_wdata = host_din[BYTE_W-1:0];
          end else begin
            ev_wr = 1'b1;
          end
        end else if (idx == ALT_IDX) begin
          ctl_wr = 1'b1;
        end
      end else if (word) begin
        if (pair == '0) begin
          hold_lo_wr = 1'b1;
          hold_hi_wr = 1'b1;
        end else begin
          ev_wr = 1'b1;
          od_wr = 1'b1;
        end
      end else if (lo_only) begin
        if (idx == '0) begin
          hold_lo_wr = 1'b1;
        end else if (a0) begin
          od_wr    = 1'b1;
          od_wdata = host_din[BYTE_W-1:0];
        end else begin
          ev_wr = 1'b1;
        end
      end else if (hi_only) begin
        od_wr = 1'b1;
      end
    end
  end

  // ---------------- read steering ----------------
  logic [DW-1:0] rd_data;
  logic          p16;
  logic [BYTE_W-1:0] byte_sel;

  assign byte_sel = a0 ? od_rd : ev_rd;

  always_comb begin
    rd_data = {FILL, FILL};
    if (is_attr) begin
      if (word || (lo_only && !a0)) rd_data = {FILL, attr_rd};
    end else if (is_disk) begin
      if (lo_only) begin
        if (idx == '0) rd_data = hold_rd;
        else           rd_data = {FILL, byte_sel};
      end else if (idx == ALT_IDX) begin
        rd_data = {FILL, status_rd};
      end
    end else if (word) begin
      rd_data = (pair == '0) ? hold_rd : {od_rd, ev_rd};
    end else if (lo_only) begin
      rd_data = {FILL, (idx == '0) ? hold_rd[BYTE_W-1:0] : byte_sel};
    end else if (hi_only) begin
      rd_data = {od_rd, FILL};
    end
  end

  assign p16 = io_path_ok && sel_ok &&
               (is_disk ? (lo_only && idx == '0) : (tf_win && pair == '0));

  // ---------------- registered host outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      host_dout <= '1;
      host_doe  <= 1'b0;
      port16_n  <= 1'b1;
    end else begin
      host_dout <= rd_data;
      host_doe  <= rd_act;
      port16_n  <= ~p16;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  mode_o,
  input logic        host_doe,
  input logic [15:0] host_dout,
  input logic        port16_n,
  input logic        rd_act
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  p_disk_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'd2 |=> mode_o == 2'd2);

  p_rd_drive_r12: assert property (@(posedge clk) disable iff (rst)
    rd_act |=> host_doe);

  p_idle_float_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_act |=> !host_doe);

  p_mem_wide_off_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0 && $past(mode_o) == 2'd0) |-> port16_n);

  p_disk_byte_lane_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2 && host_doe && port16_n) |-> host_dout[15:8] == 8'hFF);
endmodule

bind card_bus_decoder cbd_checker u_cbd_checker (
  .clk       (clk),
  .rst       (rst),
  .mode_o    (mode_o),
  .host_doe  (host_doe),
  .host_dout (host_dout),
  .port16_n  (port16_n),
  .rd_act    (rd_act)
);

// File: tb/card_bus_decoder_tb_top.sv
module card_bus_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] host_addr = '0;
  logic        ce_lo_n = 1'b1, ce_hi_n = 1'b1, reg_n = 1'b1;
  logic        oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
  logic [15:0] host_din = '0;
  logic [15:0] host_dout;
  logic        host_doe, port16_n;
  logic [1:0]  mode_o;
  logic [7:0]  ctl_byte_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_bus_decoder dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr),
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .reg_n(reg_n),
    .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .port16_n(port16_n), .mode_o(mode_o), .ctl_byte_o(ctl_byte_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst  = 1'b1;
    oe_n = strap;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_wr(input bit io, input logic rg, input logic lo, input logic hi,
                        input logic [10:0] a, input logic [15:0] d, input logic [15:0] d_end);
    @(negedge clk);
    host_addr = a; host_din = d; reg_n = rg; ce_lo_n = lo; ce_hi_n = hi;
    repeat (2) @(negedge clk);
    if (io) iowr_n = 1'b0; else we_n = 1'b0;
    repeat (4) @(negedge clk);
    host_din = d_end;
    repeat (2) @(negedge clk);
    iowr_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk);
    ce_lo_n = 1'b1; ce_hi_n = 1'b1; reg_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_rd(input bit io, input logic rg, input logic lo, input logic hi,
                        input logic [10:0] a, output logic [15:0] q,
                        output logic e, output logic p);
    @(negedge clk);
    host_addr = a; reg_n = rg; ce_lo_n = lo; ce_hi_n = hi;
    repeat (2) @(negedge clk);
    if (io) iord_n = 1'b0; else oe_n = 1'b0;
    repeat (6) @(negedge clk);
    q = host_dout; e = host_doe; p = port16_n;
    iord_n = 1'b1; oe_n = 1'b1;
    repeat (5) @(negedge clk);
    ce_lo_n = 1'b1; ce_hi_n = 1'b1; reg_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    do_reset(1'b1);
    chk("R1 mode after reset, strap high", mode_o, 2'd0);
    chk("R12 doe after reset", host_doe, 1'b0);
    chk("R11 port16_n after reset", port16_n, 1'b1);
  endtask

  task automatic t_io_ignored;
    logic [15:0] q; logic e, p;
    bus_wr(0, 1, 0, 1, 11'd2, 16'h0011, 16'h0011);
    bus_wr(1, 0, 0, 1, 11'd2, 16'h0077, 16'h0077);
    bus_rd(0, 1, 0, 1, 11'd2, q, e, p);
    chk("R2 iowr ignored in memory mode", q, 16'hFF11);
    chk("R11 port16_n high in memory mode", p, 1'b1);
    bus_rd(1, 0, 0, 1, 11'd2, q, e, p);
    chk("R2 iord does not drive in memory mode", e, 1'b0);
  endtask

  task automatic t_lanes;
    logic [15:0] q; logic e, p;
    bus_wr(0, 1, 0, 0, 11'd4, 16'hB2A1, 16'hB2A1);
    bus_rd(0, 1, 0, 0, 11'd4, q, e, p);
    chk("R4 word read pair 2", q, 16'hB2A1);
    chk("R12 doe during read", e, 1'b1);
    chk("R12 doe released after read", host_doe, 1'b0);
    bus_rd(0, 1, 0, 1, 11'd5, q, e, p);
    chk("R5 odd byte on low lane", q, 16'hFFB2);
    bus_rd(0, 1, 0, 1, 11'd4, q, e, p);
    chk("R5 even byte on low lane", q, 16'hFFA1);
    bus_rd(0, 1, 1, 0, 11'd5, q, e, p);
    chk("R6 high enable reads odd byte", q, 16'hB2FF);
    bus_wr(0, 1, 1, 0, 11'd7, 16'hC300, 16'hC300);
    bus_rd(0, 1, 0, 1, 11'd7, q, e, p);
    chk("R6 high enable writes odd byte", q, 16'hFFC3);
  endtask

  task automatic t_attr;
    logic [15:0] q; logic e, p;
    bus_wr(0, 0, 0, 0, 11'd2, 16'h995A, 16'h995A);
    bus_rd(0, 0, 0, 0, 11'd2, q, e, p);
    chk("R7 attribute word read", q, 16'hFF5A);
    bus_wr(0, 0, 0, 1, 11'd3, 16'h0033, 16'h0033);
    bus_rd(0, 0, 0, 1, 11'd3, q, e, p);
    chk("R7 odd attribute byte reads FF", q, 16'hFFFF);
    bus_rd(0, 0, 0, 1, 11'd2, q, e, p);
    chk("R7 odd attribute write dropped", q, 16'hFF5A);
    chk("R1 attribute write to index 1 keeps memory mode", mode_o, 2'd0);
  endtask

  task automatic t_trailing;
    logic [15:0] q; logic e, p;
    bus_wr(0, 1, 0, 1, 11'd6, 16'h0044, 16'h0066);
    bus_rd(0, 1, 0, 1, 11'd6, q, e, p);
    chk("R10 data taken at trailing edge", q, 16'hFF66);
  endtask

  task automatic t_io_mode;
    logic [15:0] q; logic e, p;
    bus_wr(0, 0, 0, 0, 11'd0, 16'h0001, 16'h0001);
    chk("R3 config bit enters I/O mode", mode_o, 2'd1);
    bus_wr(1, 0, 0, 0, 11'd0, 16'h1234, 16'h1234);
    bus_rd(1, 0, 0, 0, 11'd0, q, e, p);
    chk("R4 data register word in I/O mode", q, 16'h1234);
    chk("R11 port16_n low at data register", p, 1'b0);
    bus_wr(1, 0, 0, 1, 11'd2, 16'h00AB, 16'h00AB);
    bus_rd(1, 0, 0, 1, 11'd2, q, e, p);
    chk("R5 I/O byte write and read", q, 16'hFFAB);
    chk("R11 port16_n high off data register", p, 1'b1);
    bus_rd(1, 1, 0, 1, 11'd2, q, e, p);
    chk("R13 iord with reg_n high ignored", e, 1'b0);
    bus_wr(1, 1, 0, 1, 11'd2, 16'h00EE, 16'h00EE);
    bus_rd(1, 0, 0, 1, 11'd2, q, e, p);
    chk("R13 iowr with reg_n high dropped", q, 16'hFFAB);
    bus_wr(0, 0, 0, 1, 11'd0, 16'h0000, 16'h0000);
    chk("R3 clearing config bit returns to memory mode", mode_o, 2'd0);
  endtask

  task automatic t_disk;
    logic [15:0] q; logic e, p;
    do_reset(1'b0);
    chk("R1 strap low latches disk mode", mode_o, 2'd2);
    chk("R9 control byte cleared by reset", ctl_byte_o, 8'h00);
    bus_wr(0, 0, 0, 0, 11'd0, 16'h0001, 16'h0001);
    chk("R3 config write cannot leave disk mode", mode_o, 2'd2);
    bus_wr(1, 1, 0, 1, 11'h7F8, 16'hBEEF, 16'hBEEF);
    bus_rd(1, 1, 0, 1, 11'd0, q, e, p);
    chk("R8 disk data register 16 bit, upper address ignored", q, 16'hBEEF);
    chk("R11 port16_n low at disk data register", p, 1'b0);
    bus_wr(1, 1, 0, 1, 11'h403, 16'h7755, 16'h7755);
    bus_rd(1, 1, 0, 1, 11'd3, q, e, p);
    chk("R8 disk byte register on low lane", q, 16'hFF55);
    chk("R11 port16_n high at disk byte register", p, 1'b1);
    bus_wr(1, 1, 0, 1, 11'd7, 16'h0050, 16'h0050);
    bus_wr(1, 1, 0, 1, 11'd6, 16'h000C, 16'h000C);
    bus_rd(1, 1, 1, 0, 11'd6, q, e, p);
    chk("R9 alternate status mirrors status", q, 16'hFF50);
    bus_wr(1, 1, 1, 0, 11'd6, 16'h0002, 16'h0002);
    chk("R9 control byte written", ctl_byte_o, 8'h02);
    bus_rd(1, 1, 0, 1, 11'd6, q, e, p);
    chk("R9 task-file byte 6 unchanged by control write", q, 16'hFF0C);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_io_ignored();
    t_lanes();
    t_attr();
    t_trailing();
    t_io_mode();
    t_disk();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule